// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block merges event sources from three functional units (a receive path, a transmit path and a once-per-second tick unit) into a single active-high interrupt request for a local processor. Each unit owns between one and twelve low-level sources. Every source has a sticky status bit and its own enable bit. A per-unit summary bit is formed from the enabled, pending sources. A second enable level then decides which unit summaries may drive the interrupt line.

Software reaches everything over a byte-wide register bus with an address, write and read strobes, write data and combinational read data. In the interrupt handler, software reads the unit summary register to pick a branch. It then reads the matching 16-bit source status register and clears the pending bits by writing ones to them.

Top module: `irq_tree`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: A one-cycle pulse on a source event input sets that source's status bit. The bit stays set until software writes 1 to its position; writing 0 leaves it unchanged.
- R3: If an event and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R4: Source enable registers keep the bits written to them, but only for bits below the unit's source count. All bits at or above that count read as zero and ignore writes, in both the status and the enable registers.
- R5: The unit summary register at 0x05 reads bit 7 = receive, bit 1 = transmit and bit 0 = one-second. Each bit is the OR over that unit's sources of status AND enable. The register cannot be written.
- R6: The unit enable register at 0x04 uses the same bit positions (7 receive, 1 transmit, 0 one-second). Only those three bits can be written; bits 6..2 read 0.
- R7: `irq` is a register. It goes high one clock after some unit has both its summary bit and its unit enable bit set, and it goes low one clock after no unit meets that condition.
- R8: A unit whose unit enable bit is 0 cannot raise `irq`, and a source whose enable bit is 0 does not contribute to its unit's summary.
- R9: Reads of any address outside 0x04..0x11 return 0x00, and writes to those addresses change nothing.
- R10: Each source register is 16 bits wide. Its low byte (bits 7..0) is at the even address and its high byte at the odd address. Per unit u (receive = 0, transmit = 1, one-second = 2), status is at 0x06+4u/0x07+4u and enable is at 0x08+4u/0x09+4u.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | RX_N | Receive-unit event pulses |
| tx_evt | input | TX_N | Transmit-unit event pulses |
| sec_evt | input | SEC_N | One-second-unit event pulses |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high, else 0 |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench aims at the collision where an event and a clear land on the same bit in one cycle. A design that gives the clear priority would drop that event and report nothing. It writes all ones to enable registers of units with fewer than sixteen sources; a design that does not mask by source count would read back phantom bits. It also writes to the read-only summary and to unmapped addresses, where a decoder that is too loose would corrupt real state. It then checks that `irq` changes exactly one cycle after a qualifying change, neither early nor late, and that clearing either enable level silences the line.

// File: rtl/irq_tree.sv
module irq_tree #(
  parameter int RX_N  = 12,
  parameter int TX_N  = 10,
  parameter int SEC_N = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RX_N-1:0]  rx_evt,
  input  logic [TX_N-1:0]  tx_evt,
  input  logic [SEC_N-1:0] sec_evt,
  input  logic [7:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             irq
);

  localparam int NU = 3;
  localparam logic [7:0] A_BEN = 8'h04;
  localparam logic [7:0] A_BST = 8'h05;
  localparam logic [7:0] A_SRC = 8'h06;

  function automatic logic [15:0] vmask(int n);
    return 16'((32'd1 << n) - 32'd1);
  endfunction

  localparam logic [NU-1:0][15:0] VM = {vmask(SEC_N), vmask(TX_N), vmask(RX_N)};

  logic [NU-1:0][15:0] src_st, src_en, evt, clr;
  logic [NU-1:0]       blk_st, blk_en;
  logic                irq_q;

  assign evt[0] = 16'(rx_evt);
  assign evt[1] = 16'(tx_evt);
  assign evt[2] = 16'(sec_evt);

  function automatic logic [7:0] ua(int u, int off);
    return A_SRC + 8'(4 * u + off);
  endfunction

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      clr[u] = 16'h0;
      if (wr_en && addr == ua(u, 0)) clr[u][7:0]  = wdata;
      if (wr_en && addr == ua(u, 1)) clr[u][15:8] = wdata;
      blk_st[u] = |(src_st[u] & src_en[u]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_st <= '0;
      src_en <= '0;
      blk_en <= '0;
      irq_q  <= 1'b0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        src_st[u] <= ((src_st[u] & ~clr[u]) | evt[u]) & VM[u];
        if (wr_en && addr == ua(u, 2)) src_en[u][7:0]  <= wdata & VM[u][7:0];
        if (wr_en && addr == ua(u, 3)) src_en[u][15:8] <= wdata & VM[u][15:8];
      end
      if (wr_en && addr == A_BEN) blk_en <= {wdata[0], wdata[1], wdata[7]};
      irq_q <= |(blk_st & blk_en);
    end
  end

  assign irq = irq_q;

  logic [7:0] rmux;
  always_comb begin
    rmux = 8'h00;
    if (addr == A_BEN) rmux = {blk_en[0], 5'b0, blk_en[1], blk_en[2]};
    if (addr == A_BST) rmux = {blk_st[0], 5'b0, blk_st[1], blk_st[2]};
    for (int u = 0; u < NU; u++) begin
      if (addr == ua(u, 0)) rmux = src_st[u][7:0];
      if (addr == ua(u, 1)) rmux = src_st[u][15:8];
      if (addr == ua(u, 2)) rmux = src_en[u][7:0];
      if (addr == ua(u, 3)) rmux = src_en[u][15:8];
    end
  end

  assign rdata = rd_en ? rmux : 8'h00;

endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  rdata,
  input logic        irq,
  input logic [2:0]  blk_en,
  input logic [15:0] rx_st
);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr < 8'h04 || addr > 8'h11)) |-> rdata == 8'h00);

  a_r6_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 8'h04 || addr == 8'h05)) |-> rdata[6:2] == 5'b0);

  a_r8_block_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en == 3'b000) |=> !irq);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rx_st != 16'h0) |=> ((rx_st & $past(rx_st)) == $past(rx_st)));

  a_r4_rx_width: assert property (@(posedge clk) disable iff (!rst_n)
    rx_st[15:12] == 4'h0);

endmodule

bind irq_tree irq_tree_chk i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .irq(irq), .blk_en(blk_en), .rx_st(src_st[0])
);

// File: tb/test_irq_tree.sv
module test_irq_tree;
  logic clk = 0, rst_n = 0;
  logic [11:0] rx_evt = '0;
  logic [9:0]  tx_evt = '0;
  logic [0:0]  sec_evt = '0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  rdata;
  logic        irq;

  int n_tests = 0, n_fail = 0;

  typedef struct { logic [7:0] a; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  irq_tree i_irq_tree (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .sec_evt(sec_evt),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; cyc(); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.a = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    addr = a; rd_en = 1; cyc(); rd_en = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_tests++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, e);
    end
  endtask

  always @(negedge clk) begin
    if (rd_en) begin
      item_t it;
      n_tests++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty at addr %h: actual %h expected none", addr, rdata);
      end else begin
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s addr %h: actual %h expected %h", it.tag, it.a, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    // R1 reset state
    chk_irq(0, "R1");
    for (int a = 4; a <= 17; a++) rd(8'(a), 8'h00, "R1");

    // R6 unit enable bits
    wr(8'h04, 8'hFF);
    rd(8'h04, 8'h83, "R6");
    // R5 summary read-only
    wr(8'h05, 8'hFF);
    rd(8'h05, 8'h00, "R5");

    // R4 / R10 enable widths and byte order
    wr(8'h08, 8'hFF); wr(8'h09, 8'hFF);
    rd(8'h08, 8'hFF, "R4"); rd(8'h09, 8'h0F, "R4");
    wr(8'h0C, 8'hFF); wr(8'h0D, 8'hFF);
    rd(8'h0C, 8'hFF, "R4"); rd(8'h0D, 8'h03, "R4");
    wr(8'h10, 8'hFF); wr(8'h11, 8'hFF);
    rd(8'h10, 8'h01, "R4"); rd(8'h11, 8'h00, "R4");

    // R2 / R10 event on rx source 9 lands in the high byte
    rx_evt = 12'h200; cyc(); rx_evt = '0;
    chk_irq(0, "R7 not early");
    cyc();
    chk_irq(1, "R7");
    rd(8'h07, 8'h02, "R10");
    rd(8'h06, 8'h00, "R10");
    rd(8'h05, 8'h80, "R5");
    wr(8'h07, 8'h00);
    rd(8'h07, 8'h02, "R2 write 0");
    wr(8'h07, 8'h02);
    chk_irq(1, "R7 fall delay");
    cyc();
    chk_irq(0, "R7 fall");
    rd(8'h07, 8'h00, "R2 clear");

    // R3 set wins over clear
    tx_evt = 10'h001; cyc(); tx_evt = '0;
    tx_evt = 10'h001; addr = 8'h0A; wdata = 8'h01; wr_en = 1; cyc();
    tx_evt = '0; wr_en = 0;
    rd(8'h0A, 8'h01, "R3");
    rd(8'h05, 8'h02, "R5");

    // R8 unit-level gate
    wr(8'h04, 8'h81); cyc();
    chk_irq(0, "R8 unit gate");
    wr(8'h04, 8'h83); cyc();
    chk_irq(1, "R8 unit reopen");
    // R8 source-level gate
    wr(8'h0C, 8'h00);
    rd(8'h05, 8'h00, "R8 source gate");
    cyc();
    chk_irq(0, "R8 source gate");

    // one-second unit
    sec_evt = 1'b1; cyc(); sec_evt = '0;
    rd(8'h0E, 8'h01, "R2 sec");
    rd(8'h05, 8'h01, "R5 sec");
    chk_irq(1, "R7 sec");

    // R9 unmapped
    rd(8'h00, 8'h00, "R9"); rd(8'h12, 8'h00, "R9"); rd(8'hFF, 8'h00, "R9");
    wr(8'h20, 8'hFF); wr(8'h03, 8'hFF);
    rd(8'h20, 8'h00, "R9");
    rd(8'h04, 8'h83, "R9 no side effect");
    rd(8'h0C, 8'h00, "R9 no side effect");
    rd(8'h0A, 8'h01, "R9 no side effect");

    cyc();
    if (sb.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule